// File: doc/BRIEF.md
# Oscillator frequency monitor

This block measures how fast an on-chip free-running oscillator runs. It compares the oscillator against the reference clock. Software writes a window length, counted in reference cycles, and then sets the two low control bits to start a run. The block gates an edge counter that runs in the oscillator domain for exactly that window. After the window it waits for the Gray-coded count to cross into the reference domain and settle. It then posts the count and raises a done flag. At a 24 MHz reference, 24 window cycles make one microsecond.

The same oscillator also drives a programmable divider that produces a slow derived clock. A separate select register picks the output clock, either that derived clock or an external slow (32 kHz class) input. The handover between the two is glitch-free. Control words use a write mask: the upper half of the 32-bit write data says which bits of the lower half land in the register.

Top module: `osc_mon`

## Requirements
- R1: Writes to the control register (0x00) and to the select register (0x20) change only those bits n for which wdata bit n+16 is 1. Every other bit keeps its previous value.
- R2: The window register sits at 0x04, four bytes above control. It is written plainly with the low WIN_W bits of wdata and reads back the same value.
- R3: A run starts when control bits [1:0] become 2'b11. The edge counter is gated for exactly the window length in reference cycles. Once done is up, the value read at 0x14 (status + 4) equals the oscillator rising edges in that window, within ±2.
- R4: Done is status bit 0 at 0x10. Done and the count are posted in the same cycle, and the count stays stable while done stays high.
- R5: A window of 0 completes with done = 1 and a count of 0.
- R6: Once control bits [1:0] are no longer 2'b11, done and the count read back 0 at the next access, ready for a fresh run.
- R7: Control bits [7:2] hold the divide value N, and a value of 0 acts as 1. The derived clock has a period of N oscillator cycles and stays high for floor(N/2) cycles, so it has a 50% duty cycle for even N. N = 1 passes the oscillator through. Control bit 1 enables the divider. With that bit at 0 the derived clock is held low.
- R8: Select bit 6 chooses the output clock: 0 picks the external input and 1 picks the derived clock. A switch never produces a pulse shorter than the shorter half-period of the two sources.
- R9: After reset every register reads 0, done is 0 and the output follows the external input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| osc_i | input | 1 | Oscillator under measurement |
| ext_clk_i | input | 1 | External slow clock source |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Register byte address |
| wdata_i | input | 32 | Write data, mask in bits [31:16] for masked registers |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| clk_o | output | 1 | Selected output clock |

## Verification
The assertions assume a quiet oscillator domain between runs. After a run is stopped, the oscillator must see the stop before the next start, so that its counter clears. The select assertions also assume that the derived clock keeps toggling whenever the mux must hand over away from it. The stimulus leaves at least twenty reference cycles after each stop. It changes the select bit only while the divider is enabled or while the derived clock was never selected. It changes the divide value only while the external source drives the output.

// File: rtl/osc_mon_pkg.sv
`timescale 1ns/1ps
package osc_mon_pkg;
  localparam int unsigned REG_AW  = 6;
  localparam int unsigned SEL_POS = 6;

  localparam logic [REG_AW-1:0] A_CTRL = 6'h00;
  localparam logic [REG_AW-1:0] A_WIN  = 6'h04;  // control + 4
  localparam logic [REG_AW-1:0] A_STAT = 6'h10;
  localparam logic [REG_AW-1:0] A_CNT  = 6'h14;  // status + 4
  localparam logic [REG_AW-1:0] A_SEL  = 6'h20;

  typedef enum logic [1:0] {M_IDLE, M_GATE, M_SETTLE, M_DONE} meter_st_e;
endpackage

// File: rtl/osc_mon_regs.sv
`timescale 1ns/1ps
module osc_mon_regs import osc_mon_pkg::*; #(
  parameter int unsigned CTRL_W = 8,
  parameter int unsigned WIN_W  = 16,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              done_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [WIN_W-1:0]  win_o,
  output logic              sel_o,
  output logic [31:0]       rdata_o
);
  logic [CTRL_W-1:0] wmask;
  logic              unused_wdata;

  assign wmask        = wdata_i[16 +: CTRL_W];
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
      win_o  <= '0;
      sel_o  <= 1'b0;
    end else if (we_i) begin
      case (addr_i)
        A_CTRL: ctrl_o <= (ctrl_o & ~wmask) | (wdata_i[CTRL_W-1:0] & wmask);
        A_WIN:  win_o  <= wdata_i[WIN_W-1:0];
        A_SEL:  if (wdata_i[16+SEL_POS]) sel_o <= wdata_i[SEL_POS];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: rdata_o[CTRL_W-1:0] = ctrl_o;
      A_WIN:  rdata_o[WIN_W-1:0]  = win_o;
      A_STAT: rdata_o[0]          = done_i;
      A_CNT:  rdata_o[CNT_W-1:0]  = count_i;
      A_SEL:  rdata_o[SEL_POS]    = sel_o;
      default: ;
    endcase
  end
endmodule

// File: rtl/osc_mon_meter.sv
`timescale 1ns/1ps
module osc_mon_meter import osc_mon_pkg::*; #(
  parameter int unsigned WIN_W      = 16,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned SETTLE_CYC = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             osc_i,
  input  logic             run_i,
  input  logic [WIN_W-1:0] win_i,
  output logic             done_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int unsigned SET_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

  meter_st_e        st_q;
  logic             run_q, gate_q;
  logic [WIN_W-1:0] win_cnt_q;
  logic [SET_W-1:0] set_cnt_q;

  // oscillator domain
  logic [1:0]       run_sy_q, gate_sy_q;
  logic [CNT_W-1:0] osc_cnt_q, gray_q;

  always_ff @(posedge osc_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_sy_q  <= '0;
      gate_sy_q <= '0;
      osc_cnt_q <= '0;
      gray_q    <= '0;
    end else begin
      run_sy_q  <= {run_sy_q[0], run_i};
      gate_sy_q <= {gate_sy_q[0], gate_q};
      if (!run_sy_q[1])      osc_cnt_q <= '0;
      else if (gate_sy_q[1]) osc_cnt_q <= osc_cnt_q + 1'b1;
      gray_q <= osc_cnt_q ^ (osc_cnt_q >> 1);
    end
  end

  // reference domain
  logic [CNT_W-1:0] gray_s1_q, gray_s2_q, sync_bin;

  for (genvar i = 0; i < CNT_W; i++) begin : g_g2b
    assign sync_bin[i] = ^gray_s2_q[CNT_W-1:i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gray_s1_q <= '0;
      gray_s2_q <= '0;
    end else begin
      gray_s1_q <= gray_q;
      gray_s2_q <= gray_s1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= M_IDLE;
      run_q     <= 1'b0;
      gate_q    <= 1'b0;
      win_cnt_q <= '0;
      set_cnt_q <= '0;
      done_o    <= 1'b0;
      count_o   <= '0;
    end else begin
      run_q <= run_i;
      if (!run_i) begin
        st_q    <= M_IDLE;
        gate_q  <= 1'b0;
        done_o  <= 1'b0;
        count_o <= '0;
      end else begin
        case (st_q)
          M_IDLE: if (!run_q) begin
            set_cnt_q <= '0;
            if (win_i == '0) begin
              st_q <= M_SETTLE;
            end else begin
              st_q      <= M_GATE;
              gate_q    <= 1'b1;
              win_cnt_q <= win_i - 1'b1;
            end
          end
          M_GATE: begin
            if (win_cnt_q == '0) begin
              st_q   <= M_SETTLE;
              gate_q <= 1'b0;
            end else begin
              win_cnt_q <= win_cnt_q - 1'b1;
            end
          end
          M_SETTLE: begin
            if (set_cnt_q == SET_W'(SETTLE_CYC - 1)) begin
              st_q    <= M_DONE;
              done_o  <= 1'b1;
              count_o <= sync_bin;
            end else begin
              set_cnt_q <= set_cnt_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/osc_mon_div.sv
`timescale 1ns/1ps
module osc_mon_div #(
  parameter int unsigned DIV_W = 6
) (
  input  logic             osc_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             clk_o
);
  logic [1:0]       en_sy_q;
  logic             en_lo_q, out_q;
  logic [DIV_W-1:0] n, half, cnt_q, cnt_nx;

  assign n      = (div_i == '0) ? DIV_W'(1) : div_i;
  assign half   = n >> 1;
  assign cnt_nx = (cnt_q >= n - 1'b1) ? '0 : cnt_q + 1'b1;

  always_ff @(posedge osc_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_sy_q <= '0;
      cnt_q   <= '0;
      out_q   <= 1'b0;
    end else begin
      en_sy_q <= {en_sy_q[0], en_i};
      if (!en_sy_q[1]) begin
        cnt_q <= '0;
        out_q <= 1'b0;
      end else begin
        cnt_q <= cnt_nx;
        out_q <= (cnt_nx < half);
      end
    end
  end

  // gate for the pass-through case changes only while the oscillator is low
  always_ff @(negedge osc_i or negedge rst_ni) begin
    if (!rst_ni) en_lo_q <= 1'b0;
    else         en_lo_q <= en_sy_q[1];
  end

  assign clk_o = (n == DIV_W'(1)) ? (osc_i & en_lo_q) : out_q;
endmodule

// File: rtl/osc_mon_clksel.sv
`timescale 1ns/1ps
module osc_mon_clksel (
  input  logic rst_ni,
  input  logic ext_clk_i,
  input  logic div_clk_i,
  input  logic sel_i,
  output logic en_ext_o,
  output logic en_div_o,
  output logic clk_o
);
  logic ext_s1_q, div_s1_q;

  // each enable moves on its own source's falling edge, after the other has dropped
  always_ff @(negedge ext_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_s1_q <= 1'b1;
      en_ext_o <= 1'b1;
    end else begin
      ext_s1_q <= !sel_i && !en_div_o;
      en_ext_o <= ext_s1_q;
    end
  end

  always_ff @(negedge div_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_s1_q <= 1'b0;
      en_div_o <= 1'b0;
    end else begin
      div_s1_q <= sel_i && !en_ext_o;
      en_div_o <= div_s1_q;
    end
  end

  assign clk_o = (ext_clk_i & en_ext_o) | (div_clk_i & en_div_o);
endmodule

// File: rtl/osc_mon.sv
`timescale 1ns/1ps
module osc_mon import osc_mon_pkg::*; #(
  parameter int unsigned WIN_W      = 16,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned SETTLE_CYC = 16,
  parameter int unsigned DIV_W      = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              osc_i,
  input  logic              ext_clk_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              clk_o
);
  localparam int unsigned CTRL_W = DIV_W + 2;

  logic [CTRL_W-1:0] ctrl_q;
  logic [WIN_W-1:0]  win_q;
  logic              sel_q, done, div_clk, en_ext, en_div;
  logic [CNT_W-1:0]  count;

  osc_mon_regs #(.CTRL_W(CTRL_W), .WIN_W(WIN_W), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .done_i(done), .count_i(count),
    .ctrl_o(ctrl_q), .win_o(win_q), .sel_o(sel_q), .rdata_o
  );

  osc_mon_meter #(.WIN_W(WIN_W), .CNT_W(CNT_W), .SETTLE_CYC(SETTLE_CYC)) u_meter (
    .clk_i, .rst_ni, .osc_i,
    .run_i(ctrl_q[1] & ctrl_q[0]), .win_i(win_q),
    .done_o(done), .count_o(count)
  );

  osc_mon_div #(.DIV_W(DIV_W)) u_div (
    .osc_i, .rst_ni, .en_i(ctrl_q[1]), .div_i(ctrl_q[CTRL_W-1:2]), .clk_o(div_clk)
  );

  osc_mon_clksel u_sel (
    .rst_ni, .ext_clk_i, .div_clk_i(div_clk), .sel_i(sel_q),
    .en_ext_o(en_ext), .en_div_o(en_div), .clk_o
  );
endmodule

// File: rtl/osc_mon_chk.sv
`timescale 1ns/1ps
module osc_mon_chk import osc_mon_pkg::*; #(
  parameter int unsigned CTRL_W = 8,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [REG_AW-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic              sel_q,
  input logic              done,
  input logic [CNT_W-1:0]  count,
  input logic              en_ext,
  input logic              en_div
);
  assert_ctrl_nomask_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_CTRL && wdata_i[16 +: CTRL_W] == '0) |=> $stable(ctrl_q));

  assert_sel_nomask_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_SEL && !wdata_i[16+SEL_POS]) |=> $stable(sel_q));

  assert_count_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && $past(done)) |-> $stable(count));

  assert_stop_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[1:0] != 2'b11) |=> (!done && count == '0));

  assert_one_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({en_ext, en_div}));
endmodule

bind osc_mon osc_mon_chk #(.CTRL_W(CTRL_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .ctrl_q(ctrl_q), .sel_q(sel_q), .done(done), .count(count),
  .en_ext(en_ext), .en_div(en_div)
);

// File: tb/osc_mon_tb.sv
`timescale 1ns/1ps
module osc_mon_tb;
  logic        clk = 1'b0, osc = 1'b0, ext = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        clk_out;
  int          osc_half = 5;
  int          total = 0, bad = 0;
  bit          finished = 0;

  // glitch monitor
  bit          mon_en = 0, mon_valid = 0;
  time         mon_last = 0, mon_min = 1000000;

  osc_mon u_dut (
    .clk_i(clk), .rst_ni(rst_n), .osc_i(osc), .ext_clk_i(ext),
    .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .clk_o(clk_out)
  );

  always #10 clk = ~clk;
  always #(osc_half) osc = ~osc;
  always #50 ext = ~ext;

  always @(clk_out) begin
    if (mon_en) begin
      if (mon_valid && ($time - mon_last) < mon_min) mon_min = $time - mon_last;
      mon_last  = $time;
      mon_valid = 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic run_meas(input int win, output bit got, output int cnt);
    logic [31:0] d;
    got = 0;
    wr(6'h04, win);
    wr(6'h00, 32'h0003_0003);
    for (int k = 0; k < 3000; k++) begin
      rd(6'h10, d);
      if (d[0]) begin got = 1; break; end
    end
    rd(6'h14, d);
    cnt = int'(d);
  endtask

  task automatic stop_and_check();
    logic [31:0] d;
    wr(6'h00, 32'h0003_0000);
    rd(6'h10, d); chk(d[0] == 1'b0, "R6 done cleared", d[0], 0);
    rd(6'h14, d); chk(d == 0, "R6 count cleared", d, 0);
    repeat (20) @(posedge clk);
  endtask

  task automatic measure_clk(output longint high, output longint per);
    time t0, t1, t2;
    @(posedge clk_out); @(posedge clk_out);
    t0 = $time; @(negedge clk_out); t1 = $time; @(posedge clk_out); t2 = $time;
    high = longint'(t1 - t0); per = longint'(t2 - t0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL R3 watchdog expired act=0 exp=1");
      summary();
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  exp_ctrl;
    bit          exp_sel, got;
    int          cnt, cnt2, expc;
    longint      hi, per;
    int          halves[3] = '{3, 7, 15};
    int          wins[4]   = '{5, 17, 40, 100};
    int          divs[8]   = '{0, 1, 2, 3, 4, 5, 8, 63};

    repeat (3) @(negedge clk);
    rst_n = 1;

    // R9 reset state
    rd(6'h00, d); chk(d == 0, "R9 ctrl reset", d, 0);
    rd(6'h04, d); chk(d == 0, "R9 window reset", d, 0);
    rd(6'h10, d); chk(d == 0, "R9 done reset", d, 0);
    rd(6'h14, d); chk(d == 0, "R9 count reset", d, 0);
    rd(6'h20, d); chk(d == 0, "R9 select reset", d, 0);
    for (int k = 0; k < 2; k++) begin
      @(posedge ext); #5 chk(clk_out == 1'b1, "R9 output follows external high", clk_out, 1);
      @(negedge ext); #5 chk(clk_out == 1'b0, "R9 output follows external low", clk_out, 0);
    end

    // R1 select register masked writes (divider off, derived clock never taken)
    exp_sel = 0;
    for (int i = 0; i < 8; i++) begin
      logic [31:0] w;
      w = {9'h0, 1'(i % 3 == 0), 16'h0, 1'(i[0] ^ i[1]), 6'(i * 5)};
      wr(6'h20, w);
      if (w[22]) exp_sel = w[6];
      rd(6'h20, d);
      chk(d[6] == exp_sel, "R1 select masked write", d[6], exp_sel);
    end
    wr(6'h20, 32'h0040_0000);
    repeat (20) @(posedge clk);

    // R1 control register masked writes
    exp_ctrl = 0;
    for (int i = 0; i < 10; i++) begin
      logic [7:0] m, v;
      v = 8'((i * 37 + 11) & 255);
      m = (i == 4) ? 8'h00 : 8'((i * 91 + 5) & 255);
      wr(6'h00, {8'hA5, m, 8'h5A, v});
      exp_ctrl = (exp_ctrl & ~m) | (v & m);
      rd(6'h00, d);
      chk(d == {24'h0, exp_ctrl}, "R1 control masked write", d, exp_ctrl);
    end
    wr(6'h00, 32'h00FF_0000);
    repeat (20) @(posedge clk);

    // R2 window register
    wr(6'h04, 32'h0000_1234); rd(6'h04, d);
    chk(d == 32'h1234, "R2 window readback", d, 32'h1234);
    wr(6'h04, 32'hABCD_0E71); rd(6'h04, d);
    chk(d == 32'h0E71, "R2 window width", d, 32'h0E71);

    // R3 / R4 / R6 sweep of oscillator periods and windows
    foreach (halves[h]) begin
      osc_half = halves[h];
      repeat (10) @(posedge clk);
      foreach (wins[w]) begin
        run_meas(wins[w], got, cnt);
        chk(got, "R4 done raised", got, 1);
        expc = (wins[w] * 20) / (2 * halves[h]);
        chk(cnt >= expc - 2 && cnt <= expc + 2, "R3 edge count", cnt, expc);
        repeat (30) @(posedge clk);
        rd(6'h14, d); cnt2 = int'(d);
        chk(cnt2 == cnt, "R4 count held while done", cnt2, cnt);
        stop_and_check();
      end
    end

    // R5 zero window
    osc_half = 5;
    repeat (10) @(posedge clk);
    run_meas(0, got, cnt);
    chk(got, "R5 zero window done", got, 1);
    chk(cnt == 0, "R5 zero window count", cnt, 0);
    stop_and_check();

    // R7 / R8 divider sweep with select
    foreach (divs[i]) begin
      int n;
      n = (divs[i] == 0) ? 1 : divs[i];
      wr(6'h00, 32'h00FF_0000 | 32'(divs[i] << 2) | 32'h2);
      repeat (20) @(posedge clk);
      wr(6'h20, 32'h0040_0040);
      repeat (150) @(posedge clk);
      measure_clk(hi, per);
      chk(per == n * 10, "R7 derived period", per, n * 10);
      chk(hi == ((n == 1) ? 5 : (n / 2) * 10), "R7 derived high time", hi, (n == 1) ? 5 : (n / 2) * 10);
      wr(6'h20, 32'h0040_0000);
      repeat (150) @(posedge clk);
    end

    // R8 external selected again
    measure_clk(hi, per);
    chk(per == 100, "R8 external period", per, 100);
    chk(hi == 50, "R8 external high time", hi, 50);

    // R8 glitch-free handover, divide by 4 (20 ns halves) against 50 ns halves
    wr(6'h00, 32'h00FF_0012);
    repeat (20) @(posedge clk);
    mon_valid = 0; mon_min = 1000000; mon_en = 1;
    for (int k = 0; k < 6; k++) begin
      wr(6'h20, (k % 2 == 0) ? 32'h0040_0040 : 32'h0040_0000);
      repeat (40 + 7 * k) @(posedge clk);
    end
    mon_en = 0;
    chk(mon_min >= 20, "R8 no short pulse on switch", longint'(mon_min), 20);

    // R7 divider disabled holds derived clock low (derived clock selected)
    wr(6'h20, 32'h0040_0040);
    repeat (100) @(posedge clk);
    wr(6'h00, 32'h0002_0000);
    repeat (10) @(posedge clk);
    begin
      bit seen_hi;
      seen_hi = 0;
      for (int k = 0; k < 40; k++) begin #7; if (clk_out) seen_hi = 1; end
      chk(!seen_hi, "R7 disabled divider held low", seen_hi, 0);
    end
    wr(6'h00, 32'h0002_0002);
    repeat (20) @(posedge clk);
    measure_clk(hi, per);
    chk(per == 40, "R7 re-enabled period", per, 40);
    wr(6'h20, 32'h0040_0000);
    repeat (150) @(posedge clk);

    summary();
  end
endmodule